// File: doc/BRIEF.md
# Processor Status Word Register Unit

This block keeps the 128-bit status word of a processor and checks every new word offered to it. A load is a one-cycle strobe carrying a full 128-bit value. The block accepts the value only if every reserved field is clear, the two addressing-mode bits form a legal pair, and the instruction address fits the width that those bits select. A rejected value leaves the register as it was. In the cycle after the strobe, the block raises a one-cycle specification-exception pulse.

The low half of the word holds the instruction address. Each time the execution pipeline reports a completed instruction, the block moves that address forward. A taken branch loads the resolved target. Any other instruction adds its length in bytes. Both results are cut to the current addressing width, so that a narrow address is always zero-extended to 64 bits. A completion with an unsupported length changes nothing and raises an error pulse. The condition code, protection key, address-space control, state bits and interrupt masks come straight out of the register.

Top module: `psw_unit`

In this brief and the bench, bit n of the status word means the architectural bit numbered from the most significant end. It is held in vector index 127-n, so the address (bits 64..127) occupies `status_word[63:0]`.

## Requirements
- R1: After reset, the whole status word is zero. `addr_mode` is 0 (24-bit), `inst_addr` is 0, and `spec_exc` and `len_err` are low.
- R2: `addr_mode` decodes the pair {bit 31, bit 32} of the stored word: 00 gives 0 (24-bit), 01 gives 1 (31-bit) and 11 gives 2 (64-bit).
- R3: A legal load appears in `status_word` one cycle after the strobe, and the field outputs follow these bits: `cond_code` = bits 18-19, `prot_key` = bits 8-11, `space_ctl` = bits 16-17, `prog_mask` = bits 20-23 (the lowest bit number is the MSB of each field), `trace_en` = bit 1, `xlate_en` = bit 5, `io_mask` = bit 6, `ext_mask` = bit 7, `mcheck_mask` = bit 13, `wait_en` = bit 14, `problem_en` = bit 15.
- R4: A load in which any of bits 0, 2-4, 12, 24-30 or 33-63 is set is rejected. `spec_exc` pulses in the next cycle and the stored word is unchanged.
- R5: A load with bit 31 = 1 and bit 32 = 0 is rejected as in R4, and such a word is never stored.
- R6: A load is rejected as in R4 if any address bit above the selected width is set: bits 64-103 in 24-bit mode, or bits 64-96 in 31-bit mode (which includes bit 96).
- R7: A completion without a taken branch and with length 2, 4 or 6 sets the address to (address + length) modulo 2^24, 2^31 or 2^64 according to the mode. The address bits above the mode width stay zero.
- R8: A completion with a taken branch and a legal length sets the address to the branch target, with every bit above the mode width cleared.
- R9: A completion whose length is not 2, 4 or 6 leaves the address unchanged and pulses `len_err` in the next cycle.
- R10: When a load strobe and a completion fall in the same cycle, the load alone takes effect, whether it is accepted or rejected. The completion is dropped and raises no `len_err`.
- R11: `spec_exc` is high only in a cycle that follows a load strobe, and it stays high for that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load strobe for a new status word |
| ld_word | input | 128 | Status word offered for loading |
| done_valid | input | 1 | An instruction has completed |
| done_len | input | 4 | Length of the completed instruction in bytes |
| done_taken | input | 1 | The completed instruction was a taken branch |
| done_target | input | 64 | Resolved branch target |
| status_word | output | 128 | Stored status word |
| addr_mode | output | 2 | Addressing mode: 0 = 24-bit, 1 = 31-bit, 2 = 64-bit |
| inst_addr | output | 64 | Zero-extended instruction address |
| cond_code | output | 2 | Condition code |
| prot_key | output | 4 | Storage protection key |
| space_ctl | output | 2 | Address-space control: primary, access-register, secondary, home |
| wait_en | output | 1 | Wait state enabled |
| problem_en | output | 1 | Problem (unprivileged) state |
| trace_en | output | 1 | Program event recording enabled |
| xlate_en | output | 1 | Address translation enabled |
| io_mask | output | 1 | I/O interrupt mask |
| ext_mask | output | 1 | External interrupt mask |
| mcheck_mask | output | 1 | Machine-check mask |
| prog_mask | output | 4 | Program exception masks |
| spec_exc | output | 1 | One-cycle pulse: the last load was rejected |
| len_err | output | 1 | One-cycle pulse: the last completion had an illegal length |

## Verification
A status-word load and an instruction completion can arrive in the same cycle. This case is provoked by raising `ld_valid` and `done_valid` on the same clock edge, once with a legal word and a legal length, and once with an illegal word and an illegal length. In each case the stored word must equal the result of the load alone: the loaded word when it is accepted, the previous word when it is rejected. `len_err` must stay low while `spec_exc` follows only the word's legality. The bench also sweeps single set bits across the control half of the word and across every address bit in each mode, and it checks the wrapping of sequential addresses at the top of each address width.

// File: rtl/psw_pkg.sv
package psw_pkg;

  localparam int PSW_W  = 128;
  localparam int ADDR_W = PSW_W / 2;
  localparam int CTL_W  = PSW_W - ADDR_W;

  // architectural bit n sits at vector index PSW_W-1-n
  localparam int IX_EXT_MODE   = PSW_W - 1 - 31;
  localparam int IX_BASIC_MODE = PSW_W - 1 - 32;
  localparam int IX_TRACE      = PSW_W - 1 - 1;
  localparam int IX_XLATE      = PSW_W - 1 - 5;
  localparam int IX_IO_MASK    = PSW_W - 1 - 6;
  localparam int IX_EXT_MASK   = PSW_W - 1 - 7;
  localparam int IX_KEY_HI     = PSW_W - 1 - 8;
  localparam int IX_KEY_LO     = PSW_W - 1 - 11;
  localparam int IX_MCHECK     = PSW_W - 1 - 13;
  localparam int IX_WAIT       = PSW_W - 1 - 14;
  localparam int IX_PROBLEM    = PSW_W - 1 - 15;
  localparam int IX_ASC_HI     = PSW_W - 1 - 16;
  localparam int IX_ASC_LO     = PSW_W - 1 - 17;
  localparam int IX_CC_HI      = PSW_W - 1 - 18;
  localparam int IX_CC_LO      = PSW_W - 1 - 19;
  localparam int IX_PGM_HI     = PSW_W - 1 - 20;
  localparam int IX_PGM_LO     = PSW_W - 1 - 23;

  typedef enum logic [1:0] {
    MODE_24 = 2'd0,
    MODE_31 = 2'd1,
    MODE_64 = 2'd2
  } amode_t;

  // control-half bits that a loaded word must leave clear
  function automatic logic [PSW_W-1:0] build_rsv_mask();
    logic [PSW_W-1:0] m;
    m = '0;
    for (int n = 0; n < CTL_W; n++) begin
      if (n == 0 || (n >= 2 && n <= 4) || n == 12 ||
          (n >= 24 && n <= 30) || n >= 33)
        m[PSW_W-1-n] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [PSW_W-1:0] RSV_MASK = build_rsv_mask();

  function automatic amode_t decode_mode(input logic ext, input logic basic);
    case ({ext, basic})
      2'b00:   return MODE_24;
      2'b01:   return MODE_31;
      default: return MODE_64;
    endcase
  endfunction

endpackage

// File: rtl/psw_load_check.sv
module psw_load_check
  import psw_pkg::*;
#(
  parameter int NARROW_W = 24,
  parameter int MID_W    = 31
) (
  input  logic [PSW_W-1:0] word,
  output logic             legal
);

  logic        ext_b, basic_b;
  logic        pair_bad, rsv_bad, high_bad;
  logic [ADDR_W-1:0] addr;
  amode_t      mode;

  assign ext_b   = word[IX_EXT_MODE];
  assign basic_b = word[IX_BASIC_MODE];
  assign addr    = word[ADDR_W-1:0];

  assign pair_bad = ext_b & ~basic_b;
  assign rsv_bad  = |(word & RSV_MASK);
  assign mode     = decode_mode(ext_b, basic_b);

  always_comb begin
    case (mode)
      MODE_24: high_bad = |(addr >> NARROW_W);
      MODE_31: high_bad = |(addr >> MID_W);
      default: high_bad = 1'b0;
    endcase
  end

  assign legal = ~(pair_bad | rsv_bad | high_bad);

endmodule

// File: rtl/psw_next_addr.sv
module psw_next_addr
  import psw_pkg::*;
#(
  parameter int LEN_W    = 4,
  parameter int NARROW_W = 24,
  parameter int MID_W    = 31
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  amode_t            mode,
  input  logic [LEN_W-1:0]  len,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_addr,
  output logic              len_ok
);

  logic [ADDR_W-1:0] mask_narrow, mask_mid, mask_sel, sum;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign mask_narrow[i] = (i < NARROW_W);
    assign mask_mid[i]    = (i < MID_W);
  end

  always_comb begin
    case (mode)
      MODE_24: mask_sel = mask_narrow;
      MODE_31: mask_sel = mask_mid;
      default: mask_sel = '1;
    endcase
  end

  assign sum       = cur_addr + {{(ADDR_W-LEN_W){1'b0}}, len};
  assign next_addr = (taken ? target : sum) & mask_sel;
  assign len_ok    = (len == LEN_W'(2)) || (len == LEN_W'(4)) ||
                     (len == LEN_W'(6));

endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int LEN_W    = 4,
  parameter int NARROW_W = 24,
  parameter int MID_W    = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_valid,
  input  logic [PSW_W-1:0]   ld_word,
  input  logic               done_valid,
  input  logic [LEN_W-1:0]   done_len,
  input  logic               done_taken,
  input  logic [ADDR_W-1:0]  done_target,
  output logic [PSW_W-1:0]   status_word,
  output logic [1:0]         addr_mode,
  output logic [ADDR_W-1:0]  inst_addr,
  output logic [1:0]         cond_code,
  output logic [3:0]         prot_key,
  output logic [1:0]         space_ctl,
  output logic               wait_en,
  output logic               problem_en,
  output logic               trace_en,
  output logic               xlate_en,
  output logic               io_mask,
  output logic               ext_mask,
  output logic               mcheck_mask,
  output logic [3:0]         prog_mask,
  output logic               spec_exc,
  output logic               len_err
);

  logic [PSW_W-1:0]  word_q;
  logic              exc_q, len_err_q;
  logic              ld_legal, step_len_ok;
  logic [ADDR_W-1:0] step_addr;
  amode_t            mode_cur;

  assign mode_cur = decode_mode(word_q[IX_EXT_MODE], word_q[IX_BASIC_MODE]);

  psw_load_check #(
    .NARROW_W (NARROW_W),
    .MID_W    (MID_W)
  ) u_check (
    .word  (ld_word),
    .legal (ld_legal)
  );

  psw_next_addr #(
    .LEN_W    (LEN_W),
    .NARROW_W (NARROW_W),
    .MID_W    (MID_W)
  ) u_step (
    .cur_addr  (word_q[ADDR_W-1:0]),
    .mode      (mode_cur),
    .len       (done_len),
    .taken     (done_taken),
    .target    (done_target),
    .next_addr (step_addr),
    .len_ok    (step_len_ok)
  );

  // a load strobe always wins over a completion in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      exc_q     <= 1'b0;
      len_err_q <= 1'b0;
    end else begin
      exc_q     <= 1'b0;
      len_err_q <= 1'b0;
      if (ld_valid) begin
        if (ld_legal) word_q <= ld_word;
        else          exc_q  <= 1'b1;
      end else if (done_valid) begin
        if (step_len_ok) word_q[ADDR_W-1:0] <= step_addr;
        else             len_err_q          <= 1'b1;
      end
    end
  end

  assign status_word = word_q;
  assign addr_mode   = mode_cur;
  assign inst_addr   = word_q[ADDR_W-1:0];
  assign cond_code   = word_q[IX_CC_HI:IX_CC_LO];
  assign prot_key    = word_q[IX_KEY_HI:IX_KEY_LO];
  assign space_ctl   = word_q[IX_ASC_HI:IX_ASC_LO];
  assign prog_mask   = word_q[IX_PGM_HI:IX_PGM_LO];
  assign wait_en     = word_q[IX_WAIT];
  assign problem_en  = word_q[IX_PROBLEM];
  assign trace_en    = word_q[IX_TRACE];
  assign xlate_en    = word_q[IX_XLATE];
  assign io_mask     = word_q[IX_IO_MASK];
  assign ext_mask    = word_q[IX_EXT_MASK];
  assign mcheck_mask = word_q[IX_MCHECK];
  assign spec_exc    = exc_q;
  assign len_err     = len_err_q;

  // R4: a rejected load leaves the stored word untouched
  p_reject_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    spec_exc |-> $stable(status_word));

  // R5: the illegal mode pair is never held
  p_mode_pair_r5: assert property (@(posedge clk) disable iff (rst)
    !(status_word[IX_EXT_MODE] && !status_word[IX_BASIC_MODE]));

  // R7: address bits above the mode width stay clear
  p_addr_width_r7: assert property (@(posedge clk) disable iff (rst)
    (addr_mode == MODE_24 |-> (inst_addr >> NARROW_W) == '0) and
    (addr_mode == MODE_31 |-> (inst_addr >> MID_W) == '0));

  // R9: an illegal length leaves the address as it was
  p_len_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
    len_err |-> $stable(inst_addr));

  // R10: no length error follows a cycle carrying a load strobe
  p_load_priority_r10: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !$past(ld_valid));

  // R11: an exception pulse only follows a load strobe
  p_exc_after_load_r11: assert property (@(posedge clk) disable iff (rst)
    spec_exc |-> $past(ld_valid));

endmodule

// File: tb/psw_unit_tb.sv
`timescale 1ns/1ps
module psw_unit_tb;

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_valid;
  logic [127:0]  ld_word;
  logic          done_valid;
  logic [3:0]    done_len;
  logic          done_taken;
  logic [63:0]   done_target;
  logic [127:0]  status_word;
  logic [1:0]    addr_mode;
  logic [63:0]   inst_addr;
  logic [1:0]    cond_code;
  logic [3:0]    prot_key;
  logic [1:0]    space_ctl;
  logic          wait_en, problem_en, trace_en, xlate_en;
  logic          io_mask, ext_mask, mcheck_mask;
  logic [3:0]    prog_mask;
  logic          spec_exc, len_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  psw_unit u_dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_word(ld_word),
    .done_valid(done_valid), .done_len(done_len), .done_taken(done_taken),
    .done_target(done_target), .status_word(status_word),
    .addr_mode(addr_mode), .inst_addr(inst_addr), .cond_code(cond_code),
    .prot_key(prot_key), .space_ctl(space_ctl), .wait_en(wait_en),
    .problem_en(problem_en), .trace_en(trace_en), .xlate_en(xlate_en),
    .io_mask(io_mask), .ext_mask(ext_mask), .mcheck_mask(mcheck_mask),
    .prog_mask(prog_mask), .spec_exc(spec_exc), .len_err(len_err)
  );

  task automatic chk(input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] abit(input int n);
    return 128'd1 << (127 - n);
  endfunction

  function automatic logic [127:0] mode_bits(input int m);
    if (m == 0) return '0;
    if (m == 1) return abit(32);
    return abit(31) | abit(32);
  endfunction

  function automatic int mode_width(input int m);
    return (m == 0) ? 24 : (m == 1) ? 31 : 64;
  endfunction

  function automatic logic [63:0] width_mask(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic bit is_rsv(input int n);
    return n == 0 || (n >= 2 && n <= 4) || n == 12 ||
           (n >= 24 && n <= 30) || (n >= 33 && n <= 63);
  endfunction

  // expected field vector computed from architectural bit numbers
  function automatic logic [127:0] exp_fields(input logic [127:0] w);
    logic [127:0] f;
    f = '0;
    f[26:0] = {w[127-18], w[127-19], w[127-8], w[127-9], w[127-10],
               w[127-11], w[127-16], w[127-17], w[127-20], w[127-21],
               w[127-22], w[127-23], w[127-1], w[127-5], w[127-6],
               w[127-7], w[127-13], w[127-14], w[127-15],
               8'h00};
    return f;
  endfunction

  function automatic logic [127:0] act_fields();
    logic [127:0] f;
    f = '0;
    f[26:0] = {cond_code, prot_key, space_ctl, prog_mask, trace_en,
               xlate_en, io_mask, ext_mask, mcheck_mask, wait_en,
               problem_en, 8'h00};
    return f;
  endfunction

  task automatic do_load(input logic [127:0] w);
    @(negedge clk);
    ld_valid = 1'b1; ld_word = w;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic do_done(input logic [3:0] len, input logic tk,
                         input logic [63:0] tgt);
    @(negedge clk);
    done_valid = 1'b1; done_len = len; done_taken = tk; done_target = tgt;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  logic [127:0] held;

  initial begin
    rst = 1'b1; ld_valid = 0; ld_word = '0; done_valid = 0;
    done_len = '0; done_taken = 0; done_target = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 word", status_word, '0);
    chk("R1 mode", 128'(addr_mode), 128'd0);
    chk("R1 flags", {spec_exc, len_err}, 128'd0);
    held = '0;

    // R2 / R5: every mode pair, address zero
    for (int m = 0; m < 4; m++) begin
      logic [127:0] w;
      w = ((m & 2) ? abit(31) : '0) | ((m & 1) ? abit(32) : '0);
      do_load(w);
      if (m == 2) begin
        chk("R5 exc", 128'(spec_exc), 128'd1);
        chk("R5 kept", status_word, held);
      end else begin
        held = w;
        chk("R2 exc", 128'(spec_exc), 128'd0);
        chk("R2 mode", 128'(addr_mode), 128'((m == 0) ? 0 : (m == 1) ? 1 : 2));
      end
    end

    // R3 / R4: single bit sweep over the control half in 64-bit mode
    for (int b = 0; b < 64; b++) begin
      logic [127:0] w;
      if (b == 31 || b == 32) continue;
      w = mode_bits(2) | abit(b);
      do_load(w);
      if (is_rsv(b)) begin
        chk("R4 exc", 128'(spec_exc), 128'd1);
        chk("R4 kept", status_word, held);
        @(negedge clk);
        chk("R11 pulse", 128'(spec_exc), 128'd0);
      end else begin
        held = w;
        chk("R3 word", status_word, w);
        chk("R3 fields", act_fields(), exp_fields(w));
      end
    end

    // R3: dense field pattern
    held = mode_bits(1) | 128'h0000_0000_0000_0000_0000_0000_1234_5678;
    held = held | abit(1) | abit(6) | abit(8) | abit(10) | abit(14) |
           abit(17) | abit(18) | abit(21) | abit(23);
    do_load(held);
    chk("R3 dense", act_fields(), exp_fields(held));

    // R6: single address bit sweep in each mode
    for (int m = 0; m < 3; m++) begin
      for (int a = 0; a < 64; a++) begin
        logic [127:0] w;
        w = mode_bits(m) | (128'd1 << a);
        do_load(w);
        if (a >= mode_width(m)) begin
          chk("R6 exc", 128'(spec_exc), 128'd1);
          chk("R6 kept", status_word, held);
        end else begin
          held = w;
          chk("R6 ok", {spec_exc, status_word}, {1'b0, w});
        end
      end
    end

    // R7: wrap at the top of each width for each legal length
    for (int m = 0; m < 3; m++) begin
      for (int l = 2; l <= 6; l += 2) begin
        logic [63:0] a0, mk;
        mk = width_mask(mode_width(m));
        a0 = mk - 64'd3;
        do_load(mode_bits(m) | 128'(a0));
        do_done(4'(l), 1'b0, '0);
        chk("R7 wrap", 128'(inst_addr), 128'((a0 + 64'(l)) & mk));
        chk("R7 mode kept", 128'(addr_mode), 128'(m));
      end
    end

    // R7: back-to-back completions in 24-bit mode
    do_load(mode_bits(0) | 128'h00FF_FFF0);
    @(negedge clk);
    done_valid = 1'b1; done_len = 4'd6; done_taken = 1'b0;
    repeat (3) @(negedge clk);
    done_valid = 1'b0;
    chk("R7 burst", 128'(inst_addr), 128'h0000_0002);

    // R8: branch target truncated per mode
    for (int m = 0; m < 3; m++) begin
      do_load(mode_bits(m) | 128'h40);
      do_done(4'd4, 1'b1, 64'hDEAD_BEEF_CAFE_F00D);
      chk("R8 target", 128'(inst_addr),
          128'(64'hDEAD_BEEF_CAFE_F00D & width_mask(mode_width(m))));
    end

    // R9: every illegal length, branch and sequential
    do_load(mode_bits(1) | 128'h100);
    held = mode_bits(1) | 128'h100;
    for (int l = 0; l < 16; l++) begin
      if (l == 2 || l == 4 || l == 6) continue;
      do_done(4'(l), l[0], 64'h55);
      chk("R9 err", 128'(len_err), 128'd1);
      chk("R9 addr", status_word, held);
    end
    @(negedge clk);
    chk("R9 pulse", 128'(len_err), 128'd0);

    // R10: load and completion in the same cycle
    @(negedge clk);
    ld_valid = 1'b1; ld_word = mode_bits(2) | 128'h1000;
    done_valid = 1'b1; done_len = 4'd4; done_taken = 1'b0;
    @(negedge clk);
    ld_valid = 1'b0; done_valid = 1'b0;
    held = mode_bits(2) | 128'h1000;
    chk("R10 legal load wins", status_word, held);
    chk("R10 flags", {spec_exc, len_err}, 128'd0);
    @(negedge clk);
    ld_valid = 1'b1; ld_word = mode_bits(2) | abit(0);
    done_valid = 1'b1; done_len = 4'd5; done_taken = 1'b0;
    @(negedge clk);
    ld_valid = 1'b0; done_valid = 1'b0;
    chk("R10 rejected load wins", status_word, held);
    chk("R10 flags bad", {spec_exc, len_err}, 128'b10);

    // R11: no exception from completions alone
    do_done(4'd2, 1'b0, '0);
    chk("R11 quiet", 128'(spec_exc), 128'd0);
    chk("R7 after", 128'(inst_addr), 128'h1002);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule